// File: doc/BRIEF.md
# MAC Error Event and Interrupt Register Unit

This unit collects single-cycle event pulses from a network MAC into a sticky event register and raises one error interrupt line when a pending error event has been enabled. Software sees two 32-bit registers through a plain read/write port. The event register is cleared by writing ones to the bits to drop. The mask register is an ordinary read/write register that software updates with read-modify-write.

Not every mask bit lines up with the event bit it controls. The enable for an error event sits sixteen positions higher in the mask register than the event bit itself. Only four events count as errors, and only they can drive the interrupt: bit 14 (magic packet seen), bit 13 (timestamp FIFO ECC error), bit 9 (transmit frame ECC error) and bit 8 (receive frame ECC error). Their enables are mask bits 30, 29, 25 and 24.

The other defined event bits are:
- bit 12: receive FIFO overflow
- bit 11: transmit FIFO underflow
- bit 10: transmit FIFO overflow
- bit 2: loss of signal
- bit 1: remote fault
- bit 0: local fault

These bits latch and can be read, but they never raise the interrupt.

Top module: `mac_err_event_regs`

## Requirements
- R1: While `rst_n` is low, both registers are zero and `irq_err` is low, even when event pulses are present.
- R2: A high `evt_pulse` bit on a defined event position (14..8 or 2..0) sets that event bit at the next rising clock edge.
- R3: A write with `sel_mask`=0 clears exactly the event bits that are 1 in `wr_data` and leaves the other event bits unchanged.
- R4: Writing 0xFFFFFFFF to the event register clears every pending event.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: A write with `sel_mask`=1 stores `wr_data` in the mask register as a whole. Mask writes leave the event register unchanged, and event writes leave the mask unchanged.
- R7: `irq_err` is high exactly when, for some error bit i in {14,13,9,8}, event bit i and mask bit i+16 are both 1.
- R8: A mask bit at the same position as an error event does not enable it. Non-error events (12,11,10,2,1,0) never raise `irq_err`, whatever the mask holds.
- R9: Event positions 31..15 and 7..3 are not implemented. They never set and always read as zero.
- R10: Without a clearing write, a set event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 32 | Event pulses, one bit per event position |
| wr_en | input | 1 | Register write strobe |
| sel_mask | input | 1 | Register select: 0 event, 1 mask (used for both read and write) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register (combinational) |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions check the following on every cycle:
- a pulse always sets its bit, even against a clear;
- event bits only fall on a clearing write, and that write removes the bits it names;
- the mask follows its writes and holds otherwise;
- the interrupt is never high without a pending error event or with every error enable off;
- unimplemented event positions read as zero.

Some properties can only be shown by the bench scenarios, which compare the design each cycle against a behavioural model. These are:
- that the sixteen-bit offset between enable and event is right, and not a same-position gate;
- that non-error events stay out of the interrupt under a full mask;
- that clearing everything with one write works;
- the reset behaviour while pulses are active.

// File: rtl/mac_err_event_regs.sv
module mac_err_event_regs #(
  parameter int              W          = 32,
  parameter int              GATE_SHIFT = 16,
  parameter logic [W-1:0]    ERR_SET    = 32'h0000_6300,
  parameter logic [W-1:0]    IMPL_SET   = 32'h0000_7F07
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_pulse,
  input  logic         wr_en,
  input  logic         sel_mask,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq_err
);

  logic [W-1:0] evt_q, mask_q, clr_bits, enables;
  logic         evt_wr, mask_wr;

  assign evt_wr   = wr_en && !sel_mask;
  assign mask_wr  = wr_en && sel_mask;
  assign clr_bits = evt_wr ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_bits) | (evt_pulse & IMPL_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data;
  end

  assign enables = (mask_q >> GATE_SHIFT) & ERR_SET;
  assign irq_err = |(evt_q & enables);
  assign rd_data = sel_mask ? mask_q : evt_q;

  // a pulse wins over a same-cycle clear
  assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & IMPL_SET)) |=>
      ((evt_q & $past(evt_pulse & IMPL_SET)) == $past(evt_pulse & IMPL_SET)));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> (($past(evt_q) & ~evt_q) == '0));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wr && evt_pulse == '0) |=> ((evt_q & $past(wr_data)) == '0));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wr_data)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  assert_irq_needs_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> ((evt_q & ERR_SET) != '0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & (ERR_SET << GATE_SHIFT)) == '0) |-> !irq_err);

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_mask |-> ((rd_data & ~IMPL_SET) == '0));

endmodule

// File: tb/test_mac_err_event_regs.sv
module test_mac_err_event_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        wr_en = 1'b0;
  logic        sel_mask = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string phase = "R1";

  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;

  always #10 clk = ~clk;

  mac_err_event_regs i_mac_err_event_regs (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .sel_mask(sel_mask), .wr_data(wr_data), .rd_data(rd_data), .irq_err(irq_err)
  );

  function automatic bit is_impl(int i);
    return (i inside {14, 13, 12, 11, 10, 9, 8, 2, 1, 0});
  endfunction

  function automatic bit model_irq();
    bit r = 1'b0;
    foreach (m_evt[i])
      if (i inside {14, 13, 9, 8} && m_evt[i] && m_mask[i+16]) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_evt = '0;
      m_mask = '0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (wr_en && !sel_mask && wr_data[i]) m_evt[i] = 1'b0;
        if (evt_pulse[i] && is_impl(i)) m_evt[i] = 1'b1;
      end
      if (wr_en && sel_mask) m_mask = wr_data;
    end
    #5;
    compare();
  end

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = sel_mask ? m_mask : m_evt;
    vectors++;
    if (rd_data !== exp_rd) begin
      miscompares++;
      $display("FAIL %s rd_data actual=%h expected=%h", phase, rd_data, exp_rd);
    end
    vectors++;
    if (irq_err !== model_irq()) begin
      miscompares++;
      $display("FAIL %s irq_err actual=%b expected=%b", phase, irq_err, model_irq());
    end
  endtask

  task automatic cyc(input logic [31:0] p, input logic w, input logic s, input logic [31:0] d);
    @(negedge clk);
    evt_pulse = p; wr_en = w; sel_mask = s; wr_data = d;
  endtask

  task automatic idle(input logic s, input int n);
    for (int k = 0; k < n; k++) cyc('0, 1'b0, s, '0);
  endtask

  initial begin
    phase = "R1";
    cyc(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    cyc(32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF);
    cyc('0, 1'b0, 1'b1, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(1'b0, 2);

    phase = "R2";
    cyc(32'h0000_1000, 1'b0, 1'b0, '0);
    cyc(32'h0000_0005, 1'b0, 1'b0, '0);
    phase = "R10";
    idle(1'b0, 4);

    phase = "R9";
    cyc(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    idle(1'b0, 2);

    phase = "R3";
    cyc('0, 1'b1, 1'b0, 32'h0000_0100);
    cyc('0, 1'b1, 1'b0, 32'hFFFF_80F8);
    idle(1'b0, 2);

    phase = "R4";
    cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    idle(1'b0, 2);

    phase = "R6";
    cyc(32'h0000_0200, 1'b0, 1'b0, '0);
    cyc('0, 1'b1, 1'b1, 32'hA5A5_0F0F);
    idle(1'b1, 1);
    idle(1'b0, 1);
    cyc('0, 1'b1, 1'b0, 32'h0000_0200);
    idle(1'b1, 2);

    phase = "R7";
    cyc('0, 1'b1, 1'b1, 32'h4000_0000);
    cyc(32'h0000_4000, 1'b0, 1'b0, '0);
    idle(1'b0, 2);
    cyc('0, 1'b1, 1'b0, 32'h0000_4000);
    idle(1'b0, 1);
    cyc('0, 1'b1, 1'b1, 32'h0100_0000);
    cyc(32'h0000_0200, 1'b0, 1'b0, '0);
    cyc(32'h0000_0100, 1'b0, 1'b0, '0);
    idle(1'b0, 1);
    cyc('0, 1'b1, 1'b1, 32'h2200_0000);
    cyc(32'h0000_2000, 1'b0, 1'b0, '0);
    cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    idle(1'b0, 1);

    phase = "R8";
    cyc('0, 1'b1, 1'b1, 32'h0000_6300);
    cyc(32'h0000_6300, 1'b0, 1'b0, '0);
    idle(1'b0, 2);
    cyc('0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    cyc('0, 1'b1, 1'b1, 32'hFFFF_0000);
    cyc(32'h0000_1C07, 1'b0, 1'b0, '0);
    idle(1'b0, 2);

    phase = "R5";
    cyc(32'h0000_2000, 1'b1, 1'b0, 32'h0000_3C07);
    idle(1'b0, 2);
    cyc(32'h0000_0001, 1'b1, 1'b0, 32'hFFFF_FFFF);
    idle(1'b0, 2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule